// File: doc/BRIEF.md
# Ping-Pong DMA Buffer Address Generator

This block produces word addresses for a set of logical DMA channels that feed a serial-bus engine. Each channel holds two buffer descriptors. The active descriptor has a running address and a final address. The standby descriptor has a start address and an end address. Software loads both descriptors through a simple write port. Hardware walks the active descriptor one word per granted transfer. When the word at the final address has been moved, the standby descriptor takes its place. Software can then refill the standby slot while the new buffer drains or fills.

Each descriptor field is 16 bits wide. Its two lowest bits are reserved and always read as zero, so every buffer offset is word aligned. The emitted bus address places five high bits above the 16-bit field. Those five bits come from one of two shared base registers: one for synchronous traffic and one for asynchronous traffic. Within a base register, the receive base sits in the upper half and the transmit base in the lower half. A round-robin arbiter chooses which requesting channel drives the DMA bus in each cycle.

Top module: `ppdma_addr_gen`

## Requirements
- R1: A synchronous active-high reset clears every descriptor field, mode field, base register, flag and the arbitration pointer. While reset is applied with no requests, `dma_valid`, `dma_gnt`, `buf_done`, `buf_err` and `next_valid` are all zero.
- R2: A channel is eligible only when its 2-bit mode field (control write, data bits [1:0]) equals 00 and its request is high. A channel with any other mode code is never granted.
- R3: Every write to a descriptor field forces the two low bits of that field to zero. For example, a written value of 0x0403 is stored as 0x0400.
- R4: `dma_addr` equals {base, running address}. The 5-bit base is taken from the synchronous register when the channel's kind bit (control data bit 3) is 0, and from the asynchronous register when it is 1. Within the chosen register, the receive half (base-write data bits [20:16]) is used when the direction bit (control data bit 2) is 1, and the transmit half (data bits [4:0]) when it is 0. A base write with `cfg_ch[0]` = 0 loads the synchronous register; with `cfg_ch[0]` = 1 it loads the asynchronous register.
- R5: A grant for a word that is not the final word advances that channel's running address by 4, wrapping modulo 2^16.
- R6: A grant for the word at the final address completes the buffer. If a next buffer is pending, the channel loads its start and end into the running and final fields and clears `next_valid`. In both the pending and the non-pending case, `buf_done` pulses for one cycle on the next clock.
- R7: If a buffer completes while no next buffer is pending, the channel sets its sticky `buf_err` flag and stops requesting. A later next-buffer write loads the written start and end straight into the running and final fields, clears `buf_err` and leaves `next_valid` clear.
- R8: A next-buffer write (`cfg_sel` = 2, start in data [31:16], end in data [15:0]) to a channel that is not stalled stores the fields and sets `next_valid`. A current-buffer write (`cfg_sel` = 1, running address in [31:16], final address in [15:0]) replaces the active descriptor.
- R9: The arbiter searches from its pointer upward with wraparound and grants the first eligible channel, skipping channels that are not requesting in the same cycle. After a grant, the pointer moves to the channel after the granted one.
- R10: At most one grant bit is set in any cycle. `dma_valid` is high exactly when a grant is issued.
- R11: When a software write and a hardware update hit the same channel in one cycle, the hardware update (advance, swap or stall) is applied first and the write is applied on top of its result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Write target: 0 control, 1 current buffer, 2 next buffer, 3 base register |
| cfg_ch | input | CH_W (2) | Channel index; bit 0 selects the base register for base writes |
| cfg_wdata | input | 2*FLD_W (32) | Write data |
| ch_req | input | NUM_CH (4) | Per-channel transfer request |
| dma_valid | output | 1 | A channel holds the DMA bus this cycle |
| dma_gnt | output | NUM_CH (4) | One-hot grant |
| dma_addr | output | HI_W+FLD_W (21) | Address of the granted word |
| buf_done | output | NUM_CH (4) | One-cycle buffer completion pulse |
| buf_err | output | NUM_CH (4) | Sticky underrun/overrun flag |
| next_valid | output | NUM_CH (4) | A next buffer is pending |

## Verification
The assertions assume that `rst` is held high from time zero until the first clock edge. Their step and swap properties are scoped to cycles with no write, which keeps them from contending with the write priority of R11. Every descriptor the stimulus loads has an end address that is a whole number of words past its start, so a buffer always reaches its final word. Random writes still deliberately land on channels in the same cycle as grants, completions and stalls, and some carry nonzero reserved bits. The bench model resolves these collisions in the order R11 states.

// File: rtl/ppdma_pkg.sv
`timescale 1ns/1ps
package ppdma_pkg;

    typedef enum logic [1:0] {
        CFG_CTRL = 2'd0,
        CFG_CUR  = 2'd1,
        CFG_NXT  = 2'd2,
        CFG_BASE = 2'd3
    } cfg_sel_e;

    localparam logic [1:0] MODE_PINGPONG = 2'b00;

endpackage

// File: rtl/ppdma_rr.sv
`timescale 1ns/1ps
module ppdma_rr #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] elig,
    output logic [N-1:0] gnt,
    output logic         gvalid
);
    localparam int IW = (N > 1) ? $clog2(N) : 1;

    typedef struct packed {
        logic [IW-1:0] ptr;
    } rr_t;

    rr_t           s_q, s_d;
    logic [IW-1:0] win;

    always_comb begin
        s_d    = s_q;
        gnt    = '0;
        gvalid = 1'b0;
        win    = s_q.ptr;
        for (int k = 0; k < N; k++) begin
            int            j;
            logic [IW-1:0] idx;
            j = int'(s_q.ptr) + k;
            if (j >= N) j = j - N;
            idx = IW'(j);
            if (!gvalid && elig[idx]) begin
                gvalid   = 1'b1;
                gnt[idx] = 1'b1;
                win      = idx;
            end
        end
        if (gvalid) begin
            s_d.ptr = (win == IW'(N - 1)) ? '0 : IW'(win + 1'b1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    // R10: a single bus owner per cycle
    p_onehot_r10: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gnt));

    // R10: a grant only ever goes to an eligible channel
    p_only_elig_r10: assert property (@(posedge clk) disable iff (rst)
        (gnt & ~elig) == '0);

    // R9: work pending is never left unserved
    p_no_idle_r9: assert property (@(posedge clk) disable iff (rst)
        (|elig) |-> gvalid);

    // R9: a channel that keeps requesting is not granted twice in a row when another waits
    p_rotate_r9: assert property (@(posedge clk) disable iff (rst)
        (gvalid && $countones(elig) > 1) |=> ($countones(elig) < 2 || gnt != $past(gnt)));

endmodule

// File: rtl/ppdma_chan.sv
`timescale 1ns/1ps
module ppdma_chan
    import ppdma_pkg::*;
#(
    parameter int FLD_W = 16,
    parameter int RSV_W = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [1:0]         wr_sel,
    input  logic [2*FLD_W-1:0] wr_data,
    input  logic               req,
    input  logic               gnt,
    output logic               elig,
    output logic [FLD_W-1:0]   run_addr,
    output logic               dir_rx,
    output logic               kind_async,
    output logic               done,
    output logic               err,
    output logic               nv
);
    localparam logic [FLD_W-1:0] AMASK = {{(FLD_W-RSV_W){1'b1}}, {RSV_W{1'b0}}};
    localparam logic [FLD_W-1:0] STEP  = FLD_W'(2 ** RSV_W);

    typedef struct packed {
        logic [FLD_W-1:0] run;
        logic [FLD_W-1:0] fin;
        logic [FLD_W-1:0] nst;
        logic [FLD_W-1:0] nend;
        logic [1:0]       mode;
        logic             dir;
        logic             kind;
        logic             nv;
        logic             stall;
        logic             done;
    } ch_t;

    ch_t              s_q, s_d;
    logic             last_w;
    logic [FLD_W-1:0] hi_f, lo_f;

    assign hi_f   = wr_data[2*FLD_W-1:FLD_W] & AMASK;
    assign lo_f   = wr_data[FLD_W-1:0] & AMASK;
    assign last_w = (s_q.run == s_q.fin);

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        // hardware update first
        if (gnt) begin
            if (last_w) begin
                s_d.done = 1'b1;
                if (s_q.nv) begin
                    s_d.run = s_q.nst;
                    s_d.fin = s_q.nend;
                    s_d.nv  = 1'b0;
                end else begin
                    s_d.stall = 1'b1;
                end
            end else begin
                s_d.run = s_q.run + STEP;
            end
        end
        // software write on top of it
        if (wr_en) begin
            case (cfg_sel_e'(wr_sel))
                CFG_CTRL: begin
                    s_d.mode = wr_data[1:0];
                    s_d.dir  = wr_data[2];
                    s_d.kind = wr_data[3];
                end
                CFG_CUR: begin
                    s_d.run = hi_f;
                    s_d.fin = lo_f;
                end
                CFG_NXT: begin
                    if (s_d.stall) begin
                        s_d.run   = hi_f;
                        s_d.fin   = lo_f;
                        s_d.stall = 1'b0;
                    end else begin
                        s_d.nst  = hi_f;
                        s_d.nend = lo_f;
                        s_d.nv   = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign elig       = req && (s_q.mode == MODE_PINGPONG) && !s_q.stall;
    assign run_addr   = s_q.run;
    assign dir_rx     = s_q.dir;
    assign kind_async = s_q.kind;
    assign done       = s_q.done;
    assign err        = s_q.stall;
    assign nv         = s_q.nv;

    // R2: a channel outside ping-pong mode is never served
    p_mode_gate_r2: assert property (@(posedge clk) disable iff (rst)
        (s_q.mode != MODE_PINGPONG) |-> !gnt);

    // R5: a mid-buffer grant steps by one word
    p_step_r5: assert property (@(posedge clk) disable iff (rst)
        (gnt && !last_w && !wr_en) |=> (s_q.run == FLD_W'($past(s_q.run) + STEP)));

    // R6: completion with a pending buffer swaps it in
    p_swap_r6: assert property (@(posedge clk) disable iff (rst)
        (gnt && last_w && s_q.nv && !wr_en) |=> (s_q.run == $past(s_q.nst) && !nv && done));

    // R7: completion with nothing pending stalls the channel
    p_stall_r7: assert property (@(posedge clk) disable iff (rst)
        (gnt && last_w && !s_q.nv && !wr_en) |=> (err && !elig && done));

    // R7: the error flag holds until a next-buffer write
    p_err_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (err && !(wr_en && wr_sel == CFG_NXT)) |=> err);

    // R8: a next-buffer write to a running channel marks it pending
    p_nv_set_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == CFG_NXT && !err && !(gnt && last_w)) |=> nv);

    // R3: descriptor fields stay word aligned
    p_align_r3: assert property (@(posedge clk) disable iff (rst)
        s_q.run[RSV_W-1:0] == '0);

endmodule

// File: rtl/ppdma_addr_gen.sv
`timescale 1ns/1ps
module ppdma_addr_gen
    import ppdma_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int FLD_W  = 16,
    parameter int HI_W   = 5,
    parameter int RSV_W  = 2,
    localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int DATA_W = 2 * FLD_W,
    localparam int ADDR_W = HI_W + FLD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  logic [1:0]        cfg_sel,
    input  logic [CH_W-1:0]   cfg_ch,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic [NUM_CH-1:0] ch_req,
    output logic              dma_valid,
    output logic [NUM_CH-1:0] dma_gnt,
    output logic [ADDR_W-1:0] dma_addr,
    output logic [NUM_CH-1:0] buf_done,
    output logic [NUM_CH-1:0] buf_err,
    output logic [NUM_CH-1:0] next_valid
);
    typedef struct packed {
        logic [HI_W-1:0] s_rx;
        logic [HI_W-1:0] s_tx;
        logic [HI_W-1:0] a_rx;
        logic [HI_W-1:0] a_tx;
    } base_t;

    base_t b_q, b_d;

    logic [NUM_CH-1:0] elig;
    logic [NUM_CH-1:0] dir_a, kind_a;
    logic [FLD_W-1:0]  run_a [NUM_CH];
    logic [ADDR_W-1:0] full_a [NUM_CH];

    // base register write
    always_comb begin
        b_d = b_q;
        if (cfg_wr && cfg_sel == CFG_BASE) begin
            if (cfg_ch[0]) begin
                b_d.a_rx = cfg_wdata[FLD_W +: HI_W];
                b_d.a_tx = cfg_wdata[0 +: HI_W];
            end else begin
                b_d.s_rx = cfg_wdata[FLD_W +: HI_W];
                b_d.s_tx = cfg_wdata[0 +: HI_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) b_q <= '0;
        else     b_q <= b_d;
    end

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic            wr_i;
        logic [HI_W-1:0] hi_i;

        assign wr_i = cfg_wr && (cfg_ch == CH_W'(i));

        ppdma_chan #(
            .FLD_W (FLD_W),
            .RSV_W (RSV_W)
        ) u_chan (
            .clk        (clk),
            .rst        (rst),
            .wr_en      (wr_i),
            .wr_sel     (cfg_sel),
            .wr_data    (cfg_wdata),
            .req        (ch_req[i]),
            .gnt        (dma_gnt[i]),
            .elig       (elig[i]),
            .run_addr   (run_a[i]),
            .dir_rx     (dir_a[i]),
            .kind_async (kind_a[i]),
            .done       (buf_done[i]),
            .err        (buf_err[i]),
            .nv         (next_valid[i])
        );

        always_comb begin
            if (kind_a[i]) hi_i = dir_a[i] ? b_q.a_rx : b_q.a_tx;
            else           hi_i = dir_a[i] ? b_q.s_rx : b_q.s_tx;
        end

        assign full_a[i] = {hi_i, run_a[i]};
    end

    ppdma_rr #(
        .N (NUM_CH)
    ) u_rr (
        .clk    (clk),
        .rst    (rst),
        .elig   (elig),
        .gnt    (dma_gnt),
        .gvalid (dma_valid)
    );

    always_comb begin
        dma_addr = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (dma_gnt[i]) dma_addr = dma_addr | full_a[i];
        end
    end

    // R3: emitted addresses are word aligned
    p_addr_align_r3: assert property (@(posedge clk) disable iff (rst)
        dma_valid |-> (dma_addr[RSV_W-1:0] == '0));

    // R10: the valid strobe agrees with the grant vector
    p_valid_gnt_r10: assert property (@(posedge clk) disable iff (rst)
        dma_valid == (dma_gnt != '0));

    // R6: a completion pulse follows a grant to that channel
    p_done_after_gnt_r6: assert property (@(posedge clk) disable iff (rst)
        (buf_done & ~$past(dma_gnt)) == '0);

endmodule

// File: tb/ppdma_addr_gen_bench.sv
`timescale 1ns/1ps
module ppdma_addr_gen_bench;
    localparam int N = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [1:0]  cfg_ch = 2'd0;
    logic [31:0] cfg_wdata = '0;
    logic [3:0]  ch_req = '0;
    logic        dma_valid;
    logic [3:0]  dma_gnt;
    logic [20:0] dma_addr;
    logic [3:0]  buf_done, buf_err, next_valid;

    always #4 clk = ~clk;  // 125 MHz

    ppdma_addr_gen u_ppdma_addr_gen (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_ch(cfg_ch),
        .cfg_wdata(cfg_wdata), .ch_req(ch_req), .dma_valid(dma_valid), .dma_gnt(dma_gnt),
        .dma_addr(dma_addr), .buf_done(buf_done), .buf_err(buf_err), .next_valid(next_valid)
    );

    int n_chk = 0;
    int n_bad = 0;

    // reference state
    int m_run[N], m_fin[N], m_st[N], m_en[N], m_mode[N], m_dir[N], m_kind[N];
    bit m_nv[N], m_stall[N], m_done[N];
    int m_base[4];  // index kind*2+dir
    int m_ptr;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h @%0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < N; i++) begin
            m_run[i] = 0; m_fin[i] = 0; m_st[i] = 0; m_en[i] = 0;
            m_mode[i] = 0; m_dir[i] = 0; m_kind[i] = 0;
            m_nv[i] = 0; m_stall[i] = 0; m_done[i] = 0;
        end
        for (int b = 0; b < 4; b++) m_base[b] = 0;
        m_ptr = 0;
    endtask

    task automatic cycle(input bit w, input int sel, input int ch, input int data, input int req);
        int gi, eg, ea;
        int ehi, elo;
        @(negedge clk);
        cfg_wr = w; cfg_sel = 2'(sel); cfg_ch = 2'(ch); cfg_wdata = 32'(data); ch_req = 4'(req);
        #1;
        gi = -1;
        for (int k = 0; k < N; k++) begin
            int j;
            j = (m_ptr + k) % N;
            if (gi < 0 && req[j] && m_mode[j] == 0 && !m_stall[j]) gi = j;
        end
        eg = (gi >= 0) ? (1 << gi) : 0;
        chk(dma_gnt == 4'(eg), "R9 R2 grant", int'(dma_gnt), eg);
        chk(dma_valid == (gi >= 0), "R10 valid", int'(dma_valid), int'(gi >= 0));
        if (gi >= 0) begin
            ea = (m_base[m_kind[gi]*2 + m_dir[gi]] << 16) | m_run[gi];
            chk(dma_addr == 21'(ea), "R4/R3/R5 address", int'(dma_addr), ea);
        end
        for (int i = 0; i < N; i++) begin
            chk(buf_done[i] == m_done[i], "R6 done", int'(buf_done[i]), int'(m_done[i]));
            chk(buf_err[i] == m_stall[i], "R7/R11 err", int'(buf_err[i]), int'(m_stall[i]));
            chk(next_valid[i] == m_nv[i], "R8/R11 next_valid", int'(next_valid[i]), int'(m_nv[i]));
        end
        // R11: hardware effect first, then the write
        for (int i = 0; i < N; i++) m_done[i] = 0;
        if (gi >= 0) begin
            m_ptr = (gi + 1) % N;
            if (m_run[gi] == m_fin[gi]) begin
                m_done[gi] = 1;
                if (m_nv[gi]) begin
                    m_run[gi] = m_st[gi]; m_fin[gi] = m_en[gi]; m_nv[gi] = 0;
                end else m_stall[gi] = 1;
            end else m_run[gi] = (m_run[gi] + 4) & 16'hFFFF;
        end
        ehi = (data >>> 16) & 16'hFFFC;
        elo = data & 16'hFFFC;
        if (w) begin
            case (sel)
                0: begin m_mode[ch] = data & 3; m_dir[ch] = (data >> 2) & 1; m_kind[ch] = (data >> 3) & 1; end
                1: begin m_run[ch] = ehi; m_fin[ch] = elo; end
                2: if (m_stall[ch]) begin
                       m_run[ch] = ehi; m_fin[ch] = elo; m_stall[ch] = 0;
                   end else begin
                       m_st[ch] = ehi; m_en[ch] = elo; m_nv[ch] = 1;
                   end
                default: begin
                    if (ch[0]) begin m_base[3] = (data >> 16) & 31; m_base[2] = data & 31; end
                    else       begin m_base[1] = (data >> 16) & 31; m_base[0] = data & 31; end
                end
            endcase
        end
    endtask

    function automatic int buf_pair(input int start, input int words, input int junk);
        int s, e;
        s = start & 16'hFFFC;
        e = (s + 4 * words) & 16'hFFFF;
        return ((s | (junk & 3)) << 16) | (e | ((junk >> 2) & 3));
    endfunction

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state at the ports
        chk(dma_valid == 1'b0, "R1 valid", int'(dma_valid), 0);
        chk(dma_gnt == '0, "R1 grant", int'(dma_gnt), 0);
        chk(buf_done == '0, "R1 done", int'(buf_done), 0);
        chk(buf_err == '0, "R1 err", int'(buf_err), 0);
        chk(next_valid == '0, "R1 next_valid", int'(next_valid), 0);
        rst = 1'b0;

        // bases: sync rx 0x11 tx 0x03, async rx 0x15 tx 0x08 (R4)
        cycle(1, 3, 0, 32'h0011_0003, 0);
        cycle(1, 3, 1, 32'h0015_0008, 0);
        // control: ch0 sync tx, ch1 sync rx, ch2 async rx, ch3 mode 01 (R2)
        cycle(1, 0, 0, 0, 0);
        cycle(1, 0, 1, 4, 0);
        cycle(1, 0, 2, 12, 0);
        cycle(1, 0, 3, 1, 0);
        // current buffers; reserved bits set on ch1 (R3)
        cycle(1, 1, 0, 32'h0400_040C, 0);
        cycle(1, 1, 1, 32'h1003_1005, 0);
        cycle(1, 1, 2, 32'h2000_2000, 0);
        cycle(1, 1, 3, 32'h3000_3010, 0);
        // next buffers for ch0 and ch1 only (R8); ch2 will stall (R7)
        cycle(1, 2, 0, 32'h0800_0808, 0);
        cycle(1, 2, 1, 32'h1100_1110, 0);

        // all request: rotation, skip of ch3, swap and stall
        for (int c = 0; c < 30; c++) cycle(0, 0, 0, 0, 4'hF);
        // refill stalled ch2 directly (R7)
        cycle(1, 2, 2, 32'h2400_2408, 4'h4);
        for (int c = 0; c < 10; c++) cycle(0, 0, 0, 0, 4'h5);

        // random phase with colliding writes (R11)
        for (int c = 0; c < 3000; c++) begin
            int r, ch, sel, dat;
            r = $urandom_range(0, 99);
            ch = $urandom_range(0, 3);
            if (r < 25) begin
                sel = $urandom_range(1, 2);
                dat = buf_pair($urandom_range(0, 16'hFFFF), $urandom_range(0, 4), $urandom_range(0, 15));
                cycle(1, sel, ch, dat, $urandom_range(0, 15));
            end else if (r < 28) begin
                dat = ($urandom_range(0, 3) == 0) ? $urandom_range(1, 3) : 0;
                dat = dat | ($urandom_range(0, 3) << 2);
                cycle(1, 0, ch, dat, $urandom_range(0, 15));
            end else if (r < 30) begin
                cycle(1, 3, ch, $urandom(), $urandom_range(0, 15));
            end else begin
                cycle(0, 0, 0, 0, $urandom_range(0, 15));
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule